// File: doc/BRIEF.md
# Cache Way Replacement Selector

This block decides which way of a set-associative cache gets overwritten when a line must be refilled. It holds a small amount of replacement history for every cache line in flip-flops. It reads the history of the line currently addressed and combines it with that line's per-way valid and lock bits. From these it presents a victim way on the same cycle. Tag storage, data storage and hit detection sit outside the block. The cache controller tells the block which line it is looking at, reports hits with the way that hit, and reports fills with the way that was written.

The associativity runs from one to four ways. A parameter selects one of three policies. The pseudo-random policy uses no per-line state and follows a free-running counter. The last-replaced policy keeps one bit per line and is legal only for two ways. The least-recently-used policy keeps a full recency ranking of the ways, packed into the fewest bits that can hold every ranking: 1 bit for two ways, 3 bits for three ways and 5 bits for four ways. With a single way the cache is direct-mapped and no history is kept.

Top module: `repl_selector`

## Requirements
- R1: With one way, `victim_way` is 0 on every cycle, whatever the other inputs.
- R2: Random policy: a counter is 0 after reset, advances by one on every clock and wraps from NUM_WAYS-1 back to 0. The candidate order is counter, counter+1, ... (modulo NUM_WAYS), so the victim equals the counter value when all ways are valid and unlocked.
- R3: Last-replaced policy (two ways only): each line holds one bit naming its victim. A fill of way w sets the bit to the other way (1-w). A hit leaves it unchanged.
- R4: LRU policy: the victim is the way whose most recent hit or fill lies furthest back. A hit or fill makes its way the most recent. When a hit and a fill reach the same line in one cycle, the filled way ends up most recent and the hit way second.
- R5: If any way of the indexed line is invalid (`way_valid` bit 0), the victim is the lowest-numbered invalid way, whatever the policy and the lock bits.
- R6: If the policy's first choice is locked (`way_lock` bit 1), the victim is the first unlocked way further along the policy's candidate order.
- R7: If every way is valid and locked, the victim is way NUM_WAYS-1.
- R8: A synchronous active-high reset puts every line in the order 0,1,2,... (least recent first) and clears the counter, so way 0 is the first victim.
- R9: A hit or fill changes only the history of the line on `line_idx` in that cycle.
- R10: `victim_way` follows `line_idx`, `way_valid` and `way_lock` in the same cycle. A hit or fill affects the victim from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_idx | input | IDX_W | Cache line addressed this cycle |
| hit_valid | input | 1 | A hit occurred on the addressed line |
| hit_way | input | WAY_W | Way that hit |
| fill_valid | input | 1 | A way of the addressed line is being filled |
| fill_way | input | WAY_W | Way being filled |
| way_valid | input | NUM_WAYS | Valid bit per way of the addressed line |
| way_lock | input | NUM_WAYS | Lock bit per way of the addressed line |
| victim_way | output | WAY_W | Way to evict for the addressed line |

## Verification
The victim is a combinational function of the addressed line's stored history and the current valid and lock inputs. The bench therefore drives all inputs just after a falling edge and compares `victim_way` one time step later, before the next rising edge. A hit or fill is registered on that rising edge. The bench's queue-based model commits the same update only after the edge, so the effect is expected in the compare of the following cycle and never in the same one. The random counter advances on every rising edge, including cycles without a miss, and the model steps its own counter on exactly those edges.

// File: rtl/repl_pkg.sv
package repl_pkg;

    typedef enum logic [1:0] {
        REPL_RANDOM = 2'd0,
        REPL_LRR    = 2'd1,
        REPL_LRU    = 2'd2
    } repl_policy_e;

    typedef logic [1:0] way_t;
    // entry 0 is the least recent way, entry n-1 the most recent
    typedef way_t [3:0] order_t;

    function automatic int hist_bits(int n);
        if (n <= 2)      return 1;
        else if (n == 3) return 3;
        else             return 5;
    endfunction

    function automatic int fact(int k);
        case (k)
            2:       return 2;
            3:       return 6;
            4:       return 24;
            default: return 1;
        endcase
    endfunction

    function automatic order_t order_identity();
        order_t o;
        for (int i = 0; i < 4; i++) o[i] = way_t'(i);
        return o;
    endfunction

    // ranked-permutation code -> recency order
    function automatic order_t rank_decode(logic [4:0] code, int n);
        order_t     o    = order_identity();
        logic [3:0] used = '0;
        int         rem  = int'(code);
        for (int i = 0; i < 4; i++) begin
            if (i < n) begin
                int radix = fact(n - 1 - i);
                int d     = rem / radix;
                int cnt   = 0;
                int sel   = 0;
                rem = rem % radix;
                for (int w = 0; w < 4; w++) begin
                    if (w < n && !used[w]) begin
                        if (cnt == d) sel = w;
                        cnt++;
                    end
                end
                o[i] = way_t'(sel);
                used[sel] = 1'b1;
            end
        end
        return o;
    endfunction

    // recency order -> ranked-permutation code
    function automatic logic [4:0] rank_encode(order_t o, int n);
        logic [3:0] used = '0;
        int         code = 0;
        for (int i = 0; i < 4; i++) begin
            if (i < n) begin
                int d = 0;
                for (int w = 0; w < 4; w++)
                    if (w < int'(o[i]) && !used[w]) d++;
                code = code + d * fact(n - 1 - i);
                used[o[i]] = 1'b1;
            end
        end
        return 5'(code);
    endfunction

    // move way w to the most-recent slot
    function automatic order_t order_touch(order_t o, way_t w, int n);
        order_t r = o;
        int     p = n - 1;
        for (int i = 0; i < 4; i++)
            if (i < n && o[i] == w) p = i;
        for (int i = 0; i < 4; i++)
            if (i >= p && i < n - 1) r[i] = o[i + 1];
        for (int i = 0; i < 4; i++)
            if (i == n - 1) r[i] = w;
        return r;
    endfunction

endpackage

// File: rtl/repl_rand_ctr.sv
module repl_rand_ctr #(
    parameter int NUM_WAYS = 4,
    localparam int CTR_W = (NUM_WAYS > 2) ? 2 : 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CTR_W-1:0] cnt_o
);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_o <= '0;
        else if (cnt_o == CTR_W'(NUM_WAYS - 1))
            cnt_o <= '0;
        else
            cnt_o <= cnt_o + 1'b1;
    end

endmodule

// File: rtl/repl_line_state.sv
module repl_line_state #(
    parameter int NUM_LINES = 16,
    parameter int SW        = 5,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             we_i,
    input  logic [SW-1:0]    wd_i,
    output logic [SW-1:0]    rd_o
);

    logic [SW-1:0] hist_q [NUM_LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LINES; i++) hist_q[i] <= '0;
        end else if (we_i) begin
            hist_q[idx_i] <= wd_i;
        end
    end

    assign rd_o = hist_q[idx_i];

endmodule

// File: rtl/repl_victim_pick.sv
module repl_victim_pick
    import repl_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  order_t              cand_i,
    input  logic [NUM_WAYS-1:0] valid_i,
    input  logic [NUM_WAYS-1:0] lock_i,
    output logic [WAY_W-1:0]    victim_o
);

    logic [3:0] v4;
    logic [3:0] l4;
    way_t       sel;

    always_comb begin
        v4 = '1;
        l4 = '0;
        v4[NUM_WAYS-1:0] = valid_i;
        l4[NUM_WAYS-1:0] = lock_i;
        sel = way_t'(NUM_WAYS - 1);
        // first unlocked candidate wins (scan backwards)
        for (int i = NUM_WAYS - 1; i >= 0; i--)
            if (!l4[cand_i[i]]) sel = cand_i[i];
        // an empty way overrides the policy, lowest first
        for (int w = NUM_WAYS - 1; w >= 0; w--)
            if (!v4[w]) sel = way_t'(w);
        victim_o = WAY_W'(sel);
    end

endmodule

// File: rtl/repl_selector.sv
module repl_selector
    import repl_pkg::*;
#(
    parameter int           NUM_WAYS  = 4,
    parameter int           NUM_LINES = 16,
    parameter repl_policy_e POLICY    = REPL_LRU,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IDX_W-1:0]    line_idx,
    input  logic                hit_valid,
    input  logic [WAY_W-1:0]    hit_way,
    input  logic                fill_valid,
    input  logic [WAY_W-1:0]    fill_way,
    input  logic [NUM_WAYS-1:0] way_valid,
    input  logic [NUM_WAYS-1:0] way_lock,
    output logic [WAY_W-1:0]    victim_way
);

    order_t cand;

    generate
        if (NUM_WAYS == 1) begin : g_direct
            assign cand = '0;
        end else if (POLICY == REPL_RANDOM) begin : g_rand
            localparam int CTR_W = (NUM_WAYS > 2) ? 2 : 1;
            logic [CTR_W-1:0] cnt;

            repl_rand_ctr #(.NUM_WAYS(NUM_WAYS)) u_ctr (
                .clk   (clk),
                .rst   (rst),
                .cnt_o (cnt)
            );

            always_comb begin
                cand = '0;
                for (int i = 0; i < NUM_WAYS; i++)
                    cand[i] = way_t'((int'(cnt) + i) % NUM_WAYS);
            end
        end else begin : g_hist
            localparam int SW = (POLICY == REPL_LRR) ? 1 : hist_bits(NUM_WAYS);
            logic [SW-1:0] rd;
            logic [SW-1:0] wd;
            logic          we;

            if (POLICY == REPL_LRR && NUM_WAYS != 2) begin : g_bad
                $error("last-replaced policy needs exactly two ways");
            end

            repl_line_state #(.NUM_LINES(NUM_LINES), .SW(SW)) u_state (
                .clk   (clk),
                .rst   (rst),
                .idx_i (line_idx),
                .we_i  (we),
                .wd_i  (wd),
                .rd_o  (rd)
            );

            if (POLICY == REPL_LRR) begin : g_lrr
                always_comb begin
                    cand    = '0;
                    cand[0] = {1'b0, rd[0]};
                    cand[1] = {1'b0, ~rd[0]};
                    we      = fill_valid;
                    wd      = SW'(~fill_way[0]);
                end
            end else begin : g_lru
                order_t cur;
                order_t nxt;
                always_comb begin
                    cur = rank_decode(5'(rd), NUM_WAYS);
                    nxt = cur;
                    if (hit_valid)  nxt = order_touch(nxt, way_t'(hit_way), NUM_WAYS);
                    if (fill_valid) nxt = order_touch(nxt, way_t'(fill_way), NUM_WAYS);
                    cand = cur;
                    we   = hit_valid | fill_valid;
                    wd   = SW'(rank_encode(nxt, NUM_WAYS));
                end
            end
        end
    endgenerate

    repl_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .cand_i   (cand),
        .valid_i  (way_valid),
        .lock_i   (way_lock),
        .victim_o (victim_way)
    );

endmodule

// File: rtl/repl_selector_chk.sv
module repl_selector_chk
    import repl_pkg::*;
#(
    parameter int           NUM_WAYS  = 4,
    parameter int           NUM_LINES = 16,
    parameter repl_policy_e POLICY    = REPL_LRU,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic                clk,
    input logic                rst,
    input logic [IDX_W-1:0]    line_idx,
    input logic                hit_valid,
    input logic [WAY_W-1:0]    hit_way,
    input logic                fill_valid,
    input logic [WAY_W-1:0]    fill_way,
    input logic [NUM_WAYS-1:0] way_valid,
    input logic [NUM_WAYS-1:0] way_lock,
    input logic [WAY_W-1:0]    victim_way
);

    logic [3:0] v4;
    logic [3:0] l4;
    always_comb begin
        v4 = '1;
        l4 = '0;
        v4[NUM_WAYS-1:0] = way_valid;
        l4[NUM_WAYS-1:0] = way_lock;
    end

    // R5
    empty_way_first_chk: assert property (@(posedge clk) disable iff (rst)
        !(&way_valid) |-> !v4[victim_way]);

    // R6
    skip_locked_chk: assert property (@(posedge clk) disable iff (rst)
        ((&way_valid) && !(&way_lock)) |-> !l4[victim_way]);

    // R7
    all_locked_chk: assert property (@(posedge clk) disable iff (rst)
        ((&way_valid) && (&way_lock)) |-> (victim_way == WAY_W'(NUM_WAYS - 1)));

    // R8
    reset_first_victim_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(rst) && (&way_valid) && !(|way_lock)) |-> (victim_way == '0));

    generate
        if (NUM_WAYS == 1) begin : g_dm
            // R1
            direct_map_chk: assert property (@(posedge clk) disable iff (rst)
                victim_way == '0);
        end
        if (NUM_WAYS > 1 && POLICY != REPL_RANDOM) begin : g_hist
            // R4
            fill_not_next_chk: assert property (@(posedge clk) disable iff (rst)
                fill_valid |=> (line_idx != $past(line_idx) || !(&way_valid) ||
                                (|way_lock) || victim_way != $past(fill_way)));
        end
        if (NUM_WAYS > 1 && POLICY == REPL_LRU) begin : g_lru
            // R4
            hit_not_next_chk: assert property (@(posedge clk) disable iff (rst)
                (hit_valid && !fill_valid) |=> (line_idx != $past(line_idx) ||
                    !(&way_valid) || (|way_lock) || victim_way != $past(hit_way)));
        end
    endgenerate

endmodule

bind repl_selector repl_selector_chk #(
    .NUM_WAYS  (NUM_WAYS),
    .NUM_LINES (NUM_LINES),
    .POLICY    (POLICY)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_idx   (line_idx),
    .hit_valid  (hit_valid),
    .hit_way    (hit_way),
    .fill_valid (fill_valid),
    .fill_way   (fill_way),
    .way_valid  (way_valid),
    .way_lock   (way_lock),
    .victim_way (victim_way)
);

// File: tb/repl_selector_test.sv
module repl_selector_test;
    import repl_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] line_idx = '0;
    logic       hit_valid = 1'b0;
    logic [1:0] hit_way = '0;
    logic       fill_valid = 1'b0;
    logic [1:0] fill_way = '0;
    logic [3:0] way_valid = '0;
    logic [3:0] way_lock = '0;

    logic [1:0] vic_lru;
    logic [0:0] vic_lrr;
    logic [1:0] vic_rnd;
    logic [0:0] vic_dm;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    repl_selector #(.NUM_WAYS(4), .NUM_LINES(NL), .POLICY(REPL_LRU)) uut (
        .clk(clk), .rst(rst), .line_idx(line_idx),
        .hit_valid(hit_valid), .hit_way(hit_way),
        .fill_valid(fill_valid), .fill_way(fill_way),
        .way_valid(way_valid), .way_lock(way_lock), .victim_way(vic_lru));

    repl_selector #(.NUM_WAYS(2), .NUM_LINES(NL), .POLICY(REPL_LRR)) uut_lrr (
        .clk(clk), .rst(rst), .line_idx(line_idx),
        .hit_valid(hit_valid), .hit_way(hit_way[0:0]),
        .fill_valid(fill_valid), .fill_way(fill_way[0:0]),
        .way_valid(way_valid[1:0]), .way_lock(way_lock[1:0]), .victim_way(vic_lrr));

    repl_selector #(.NUM_WAYS(3), .NUM_LINES(NL), .POLICY(REPL_RANDOM)) uut_rnd (
        .clk(clk), .rst(rst), .line_idx(line_idx),
        .hit_valid(hit_valid), .hit_way(hit_way),
        .fill_valid(fill_valid), .fill_way(fill_way),
        .way_valid(way_valid[2:0]), .way_lock(way_lock[2:0]), .victim_way(vic_rnd));

    repl_selector #(.NUM_WAYS(1), .NUM_LINES(NL), .POLICY(REPL_LRU)) uut_dm (
        .clk(clk), .rst(rst), .line_idx(line_idx),
        .hit_valid(hit_valid), .hit_way(1'b0),
        .fill_valid(fill_valid), .fill_way(1'b0),
        .way_valid(way_valid[0:0]), .way_lock(way_lock[0:0]), .victim_way(vic_dm));

    // reference state
    int lru_q [NL][$];
    bit lrr_b [NL];
    int rcnt;

    function automatic void model_reset();
        for (int l = 0; l < NL; l++) begin
            lru_q[l] = {0, 1, 2, 3};
            lrr_b[l] = 1'b0;
        end
        rcnt = 0;
    endfunction

    function automatic void lru_use(int l, int w);
        for (int i = 0; i < lru_q[l].size(); i++) begin
            if (lru_q[l][i] == w) begin
                lru_q[l].delete(i);
                break;
            end
        end
        lru_q[l].push_back(w);
    endfunction

    function automatic int pick(int cand[$], int v, int lk, int n);
        for (int w = 0; w < n; w++)
            if (((v >> w) & 1) == 0) return w;
        foreach (cand[i])
            if (((lk >> cand[i]) & 1) == 0) return cand[i];
        return n - 1;
    endfunction

    task automatic check(string tag, string who, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: victim got %0d expected %0d (t=%0t)", tag, who, act, exp, $time);
        end
    endtask

    task automatic step(string tag, bit r, int idx, bit hv, int hw, bit fv, int fw, int v, int lk);
        int c_lru[$];
        int c_lrr[$];
        int c_rnd[$];
        @(negedge clk);
        rst        = r;
        line_idx   = 3'(idx);
        hit_valid  = hv;
        hit_way    = 2'(hw);
        fill_valid = fv;
        fill_way   = 2'(fw);
        way_valid  = 4'(v);
        way_lock   = 4'(lk);
        #1;
        c_lru = lru_q[idx];
        c_lrr = {int'(lrr_b[idx]), int'(!lrr_b[idx])};
        c_rnd = {rcnt % 3, (rcnt + 1) % 3, (rcnt + 2) % 3};
        check(tag, "lru4", int'(vic_lru), pick(c_lru, v, lk, 4));
        check(tag, "lrr2", int'(vic_lrr), pick(c_lrr, v & 3, lk & 3, 2));
        check(tag, "rnd3", int'(vic_rnd), pick(c_rnd, v & 7, lk & 7, 3));
        check("R1", "dm1", int'(vic_dm), 0);
        @(posedge clk);
        if (r) begin
            model_reset();
        end else begin
            if (hv) lru_use(idx, hw);
            if (fv) begin
                lru_use(idx, fw);
                lrr_b[idx] = ((fw & 1) == 0);
            end
            rcnt = (rcnt + 1) % 3;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R8: reset state, way 0 first
        step("R8", 1, 0, 0, 0, 0, 0, 15, 0);
        step("R8", 1, 3, 1, 2, 1, 1, 15, 0);
        step("R8", 0, 0, 0, 0, 0, 0, 15, 0);
        step("R8", 0, 5, 0, 0, 0, 0, 15, 0);

        // R4: recency on line 2
        step("R4", 0, 2, 1, 0, 0, 0, 15, 0);
        step("R4", 0, 2, 1, 1, 0, 0, 15, 0);
        step("R4", 0, 2, 0, 0, 1, 2, 15, 0);
        step("R4", 0, 2, 1, 0, 0, 0, 15, 0);
        step("R4", 0, 2, 1, 3, 1, 1, 15, 0);
        step("R4", 0, 2, 0, 0, 0, 0, 15, 0);

        // R9: other lines untouched
        step("R9", 0, 5, 1, 0, 1, 1, 15, 0);
        step("R9", 0, 5, 1, 2, 0, 0, 15, 0);
        step("R9", 0, 2, 0, 0, 0, 0, 15, 0);
        step("R9", 0, 6, 0, 0, 0, 0, 15, 0);

        // R3: last-replaced bit, hits ignored
        step("R3", 0, 4, 0, 0, 1, 0, 15, 0);
        step("R3", 0, 4, 1, 1, 0, 0, 15, 0);
        step("R3", 0, 4, 1, 0, 0, 0, 15, 0);
        step("R3", 0, 4, 0, 0, 1, 1, 15, 0);
        step("R3", 0, 4, 1, 0, 0, 0, 15, 0);

        // R2: counter walks and wraps
        for (int i = 0; i < 7; i++) step("R2", 0, i, 0, 0, 0, 0, 15, 0);

        // R5: empty ways win
        step("R5", 0, 2, 0, 0, 0, 0, 4'b1011, 0);
        step("R5", 0, 2, 0, 0, 0, 0, 4'b0110, 4'b0001);
        step("R5", 0, 2, 0, 0, 0, 0, 4'b0111, 4'b1111);
        step("R5", 0, 1, 0, 0, 0, 0, 4'b1101, 0);

        // R6 / R7: locks
        step("R6", 0, 2, 0, 0, 0, 0, 15, 4'b0001);
        step("R6", 0, 2, 0, 0, 0, 0, 15, 4'b1011);
        step("R6", 0, 4, 0, 0, 0, 0, 15, 4'b0011);
        step("R6", 0, 3, 0, 0, 0, 0, 15, 4'b0110);
        step("R7", 0, 2, 0, 0, 0, 0, 15, 4'b1111);
        step("R7", 0, 4, 0, 0, 0, 0, 15, 4'b1111);

        // R10: same-cycle follow of index, update next cycle
        step("R10", 0, 7, 1, 3, 0, 0, 15, 0);
        step("R10", 0, 7, 0, 0, 1, 0, 15, 0);
        step("R10", 0, 0, 0, 0, 0, 0, 15, 0);
        step("R10", 0, 7, 0, 0, 0, 0, 15, 0);

        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            int v  = ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 15)) : 15;
            int lk = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 15)) : 0;
            step("R4", 0, int'($urandom_range(0, NL - 1)),
                 bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                 bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)), v, lk);
        end

        // R8: reset mid-run restores first-victim order
        step("R8", 1, 2, 0, 0, 0, 0, 15, 0);
        step("R8", 0, 2, 0, 0, 0, 0, 15, 0);
        step("R8", 0, 6, 0, 0, 0, 0, 15, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule